// File: doc/BRIEF.md
# Fixed-Point Width Reducer with Selectable Rounding

This block narrows a fixed-point sample by removing a parameterised number of fraction bits from the bottom of the word. Everything is fixed at elaboration time: two's-complement or unsigned data, the rounding rule, and what happens when rounding runs past the top of the narrower output range. The rounding rule is plain truncation, round-to-nearest, or round-to-nearest-even. For round-to-nearest, signed ties go away from zero and unsigned ties go up. On overflow the result either wraps to the opposite extreme or is clamped at the largest positive code.

A sample enters with a valid strobe. An optional register in front of the rounding logic and an optional register behind it give a fixed latency of 0, 1 or 2 clock cycles. The strobe travels with the data through the same stages. Each stage loads only when the valid bit entering it is high. Reset is asynchronous and active-low. Its deassertion is expected to be synchronous to the clock.

Top module: `fxp_round_unit`

## Requirements
- R1: The output is IN_W-DROP bits wide. With DROP=0 the output equals the input bit for bit, whatever the mode.
- R2: With MODE=RND_TRUNC the dropped bits are discarded toward minus infinity. For IN_W=5, DROP=2: signed codes -16..-13 give -4 and 12..15 give 3, and unsigned x gives floor(x/4).
- R3: With MODE=RND_NEAREST and SIGNED_DATA=1, results round to the nearest value and exact ties go away from zero. For 5 bits with 2 dropped: -14 gives -4, -13 gives -3, -2 gives -1 and +2 gives +1.
- R4: With MODE=RND_NEAREST and SIGNED_DATA=0, results round to the nearest value and exact ties go up. For 5 bits with 2 dropped: 2 gives 1 and 6 gives 2.
- R5: With MODE=RND_EVEN, exact ties go to the even neighbour. Signed 5/2: -10 gives -2, -6 gives -2, 2 gives 0 and -2 gives 0. Unsigned: 2 gives 0, 6 gives 2 and 10 gives 2.
- R6: With SATURATE=0, a rounded result above the output range wraps to the opposite extreme. Signed 5/2: inputs 14 and 15 give -4 (code 4). Unsigned: inputs 30 and 31 give 0.
- R7: With SATURATE=1, an overflowing result is replaced by the largest positive output code: 3 for a signed 3-bit output and 7 for an unsigned one. All other results are the same as without saturation.
- R8: The latency from in_valid/in_data to out_valid/out_data is REG_IN+REG_OUT cycles, and out_valid follows in_valid with that delay.
- R9: A pipeline register loads only when the valid bit entering it is 1. Otherwise it holds, so out_data stays unchanged while out_valid is 0 in a registered configuration.
- R10: Asserting rst_n low clears out_valid and the registered data to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | IN_W | Input sample, two's complement or unsigned |
| out_valid | output | 1 | Output sample qualifier, delayed by REG_IN+REG_OUT |
| out_data | output | IN_W-DROP | Reduced-width sample |

## Verification
Data results are due REG_IN+REG_OUT rising edges after a sample is presented. The bench therefore holds each input code with in_valid high for three edges and reads every instance on the following falling edge, where all configurations from zero to two registers have settled. For latency, a single-cycle valid pulse is sent, and the strobe of each latency variant is read at each falling edge from zero to two cycles later. The hold check changes the data while valid is low and reads the registered outputs three edges later. The bound checker delays the input strobe and data by the configured latency before it compares them with the outputs.

// File: rtl/fxp_round_pkg.sv
package fxp_round_pkg;

  // Rounding rule, fixed at elaboration
  typedef enum logic [1:0] {
    RND_TRUNC   = 2'd0,  // drop bits, toward minus infinity
    RND_NEAREST = 2'd1,  // nearest; signed ties away from zero, unsigned ties up
    RND_EVEN    = 2'd2   // nearest; ties to the even neighbour
  } rnd_mode_e;

endpackage

// File: rtl/fxp_pipe_stage.sv
module fxp_pipe_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);

  logic         vld_q;
  logic [W-1:0] dat_q;
  logic [W-1:0] dat_nxt;

  // clock enable: load only on a qualified sample
  always_comb begin
    dat_nxt = vld_i ? dat_i : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_i;
      dat_q <= dat_nxt;
    end
  end

  assign vld_o = vld_q;
  assign dat_o = dat_q;

endmodule

// File: rtl/fxp_round_core.sv
module fxp_round_core
  import fxp_round_pkg::*;
#(
  parameter int        IN_W        = 16,
  parameter int        DROP        = 4,
  parameter bit        SIGNED_DATA = 1'b1,
  parameter rnd_mode_e MODE        = RND_EVEN,
  parameter bit        SATURATE    = 1'b1,
  localparam int       OUT_W       = IN_W - DROP
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);

  if (DROP == 0) begin : g_pass
    assign dout = din;
  end else begin : g_rnd
    localparam logic [DROP-1:0]  HALF    = DROP'(1) << (DROP - 1);
    localparam logic [OUT_W-1:0] SAT_MAX = SIGNED_DATA ? ({OUT_W{1'b1}} >> 1)
                                                       : {OUT_W{1'b1}};

    logic [DROP-1:0] frac;
    logic [OUT_W:0]  kept_ext;
    logic [OUT_W:0]  rsum;
    logic            tie_up;
    logic            inc;
    logic            ovf;

    always_comb begin
      frac     = din[DROP-1:0];
      kept_ext = {(SIGNED_DATA ? din[IN_W-1] : 1'b0), din[IN_W-1:DROP]};
      // direction of an exact tie
      case (MODE)
        RND_NEAREST: tie_up = !(SIGNED_DATA && din[IN_W-1]);
        RND_EVEN:    tie_up = din[DROP];
        default:     tie_up = 1'b0;
      endcase
      inc  = (MODE != RND_TRUNC) && ((frac > HALF) || ((frac == HALF) && tie_up));
      rsum = kept_ext + {{OUT_W{1'b0}}, inc};
      // carry out of the kept field
      ovf  = SIGNED_DATA ? (rsum[OUT_W] ^ rsum[OUT_W-1]) : rsum[OUT_W];
      dout = (SATURATE && ovf) ? SAT_MAX : rsum[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/fxp_round_unit.sv
module fxp_round_unit
  import fxp_round_pkg::*;
#(
  parameter int        IN_W        = 16,
  parameter int        DROP        = 4,
  parameter bit        SIGNED_DATA = 1'b1,
  parameter rnd_mode_e MODE        = RND_EVEN,
  parameter bit        SATURATE    = 1'b1,
  parameter bit        REG_IN      = 1'b1,
  parameter bit        REG_OUT     = 1'b1,
  localparam int       OUT_W       = IN_W - DROP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  logic             a_vld;
  logic [IN_W-1:0]  a_dat;
  logic [OUT_W-1:0] b_dat;

  if (REG_IN) begin : g_in_reg
    fxp_pipe_stage #(.W(IN_W)) u_in_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (in_valid),
      .dat_i (in_data),
      .vld_o (a_vld),
      .dat_o (a_dat)
    );
  end else begin : g_in_wire
    assign a_vld = in_valid;
    assign a_dat = in_data;
  end

  fxp_round_core #(
    .IN_W        (IN_W),
    .DROP        (DROP),
    .SIGNED_DATA (SIGNED_DATA),
    .MODE        (MODE),
    .SATURATE    (SATURATE)
  ) u_core (
    .din  (a_dat),
    .dout (b_dat)
  );

  if (REG_OUT) begin : g_out_reg
    fxp_pipe_stage #(.W(OUT_W)) u_out_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (a_vld),
      .dat_i (b_dat),
      .vld_o (out_valid),
      .dat_o (out_data)
    );
  end else begin : g_out_wire
    assign out_valid = a_vld;
    assign out_data  = b_dat;
  end

endmodule

// File: rtl/fxp_round_chk.sv
module fxp_round_chk
  import fxp_round_pkg::*;
#(
  parameter int        IN_W        = 16,
  parameter int        DROP        = 4,
  parameter bit        SIGNED_DATA = 1'b1,
  parameter rnd_mode_e MODE        = RND_EVEN,
  parameter bit        SATURATE    = 1'b1,
  parameter bit        REG_IN      = 1'b1,
  parameter bit        REG_OUT     = 1'b1,
  localparam int       OUT_W       = IN_W - DROP,
  localparam int       LAT         = int'(REG_IN) + int'(REG_OUT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_data,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);

  logic            v1, v2, v_lat;
  logic [IN_W-1:0] d1, d2, d_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      d1 <= '0;
      d2 <= '0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      d1 <= in_data;
      d2 <= d1;
    end
  end

  assign v_lat = (LAT == 0) ? in_valid : ((LAT == 1) ? v1 : v2);
  assign d_lat = (LAT == 0) ? in_data  : ((LAT == 1) ? d1 : d2);

  // integer model of the rounding rules
  function automatic logic [OUT_W-1:0] ref_fn(input logic [IN_W-1:0] x);
    longint v, q, r, half, top;
    logic [63:0] qb;
    v    = SIGNED_DATA ? longint'($signed(x)) : longint'(x);
    q    = v >>> DROP;
    r    = v - (q <<< DROP);
    half = (longint'(1) <<< DROP) >>> 1;
    if (MODE != RND_TRUNC && DROP > 0) begin
      if (r > half) q = q + 1;
      else if (r == half) begin
        if (MODE == RND_NEAREST) begin
          if (!(SIGNED_DATA && v < 0)) q = q + 1;
        end else if (q[0]) q = q + 1;
      end
    end
    top = SIGNED_DATA ? (longint'(1) <<< (OUT_W - 1)) - 1 : (longint'(1) <<< OUT_W) - 1;
    if (q > top) q = SATURATE ? top : q - (longint'(1) <<< OUT_W);
    qb = q;
    return qb[OUT_W-1:0];
  endfunction

  // R8
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v_lat);

  // R2 R3 R4 R5 R6 R7
  data_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data == ref_fn(d_lat));

  if (DROP == 0) begin : g_pass_chk
    // R1
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_data == d_lat);
  end

  if (SATURATE && SIGNED_DATA && DROP > 0) begin : g_sat_chk
    // R7
    sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !d_lat[IN_W-1]) |-> !out_data[OUT_W-1]);
  end

  if (LAT > 0) begin : g_hold_chk
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));
  end

endmodule

bind fxp_round_unit fxp_round_chk #(
  .IN_W        (IN_W),
  .DROP        (DROP),
  .SIGNED_DATA (SIGNED_DATA),
  .MODE        (MODE),
  .SATURATE    (SATURATE),
  .REG_IN      (REG_IN),
  .REG_OUT     (REG_OUT)
) u_fxp_round_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_fxp_round_unit.sv
module test_fxp_round_unit;
  import fxp_round_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NCFG       = 10;

  // configuration per instance: signedness, rule, clamp, input reg, output reg
  localparam bit        CS  [NCFG] = '{1, 1, 1, 1, 0, 0, 0, 0, 1, 0};
  localparam rnd_mode_e CM  [NCFG] = '{RND_NEAREST, RND_NEAREST, RND_EVEN, RND_EVEN,
                                       RND_NEAREST, RND_NEAREST, RND_EVEN, RND_EVEN,
                                       RND_TRUNC, RND_TRUNC};
  localparam bit        CSA [NCFG] = '{0, 1, 0, 1, 0, 1, 0, 1, 0, 1};
  localparam bit        CRI [NCFG] = '{1, 1, 0, 1, 1, 0, 1, 1, 0, 0};
  localparam bit        CRO [NCFG] = '{1, 0, 0, 1, 0, 0, 1, 0, 0, 1};

  // {code, signed nearest, signed even, unsigned nearest, unsigned even}, wrapping
  localparam logic [16:0] VEC [12] = '{
    {5'd2,  3'd1, 3'd0, 3'd1, 3'd0},
    {5'd6,  3'd2, 3'd2, 3'd2, 3'd2},
    {5'd10, 3'd3, 3'd2, 3'd3, 3'd2},
    {5'd14, 3'd4, 3'd4, 3'd4, 3'd4},
    {5'd15, 3'd4, 3'd4, 3'd4, 3'd4},
    {5'd16, 3'd4, 3'd4, 3'd4, 3'd4},
    {5'd18, 3'd4, 3'd4, 3'd5, 3'd4},
    {5'd19, 3'd5, 3'd5, 3'd5, 3'd5},
    {5'd22, 3'd5, 3'd6, 3'd6, 3'd6},
    {5'd26, 3'd6, 3'd6, 3'd7, 3'd6},
    {5'd30, 3'd7, 3'd0, 3'd0, 3'd0},
    {5'd31, 3'd0, 3'd0, 3'd0, 3'd0}
  };

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [4:0] in_data;
  logic       ov [NCFG];
  logic [2:0] od [NCFG];
  logic       ov_pass;
  logic [4:0] od_pass;

  int n_chk  = 0;
  int n_fail = 0;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    fxp_round_unit #(
      .IN_W(5), .DROP(2), .SIGNED_DATA(CS[g]), .MODE(CM[g]),
      .SATURATE(CSA[g]), .REG_IN(CRI[g]), .REG_OUT(CRO[g])
    ) i_fxp_round_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(ov[g]), .out_data(od[g])
    );
  end

  fxp_round_unit #(
    .IN_W(5), .DROP(0), .SIGNED_DATA(1'b1), .MODE(RND_NEAREST),
    .SATURATE(1'b1), .REG_IN(1'b1), .REG_OUT(1'b1)
  ) i_fxp_round_unit_pass (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov_pass), .out_data(od_pass)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic int model(input int code, input bit s, input rnd_mode_e m, input bit sat);
    int v, q, r, top;
    v = (s && code >= 16) ? code - 32 : code;
    q = v >>> 2;
    r = v - q * 4;
    if (m != RND_TRUNC) begin
      if (r > 2) q++;
      else if (r == 2) begin
        if (m == RND_NEAREST) begin
          if (!(s && v < 0)) q++;
        end else if (q % 2 != 0) q++;
      end
    end
    top = s ? 3 : 7;
    if (q > top) q = sat ? top : q - 8;
    return q & 7;
  endfunction

  function automatic string tag_of(input int g);
    if (CSA[g])                 return "R7";
    if (CM[g] == RND_TRUNC)     return "R2";
    if (CM[g] == RND_EVEN)      return "R5";
    return CS[g] ? "R3" : "R4";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // hold a code with valid high for three edges, then read at a falling edge
  task automatic apply(input int code);
    @(negedge clk);
    in_data  = 5'(code);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (2) @(negedge clk);
    // R10 reset state
    check("R10", "valid in reset", int'(ov[0]), 0);
    check("R10", "data in reset", int'(od[0]), 0);
    check("R10", "pass valid in reset", int'(ov_pass), 0);
    rst_n = 1'b1;

    // table walk
    foreach (VEC[i]) begin
      apply(int'(VEC[i][16:12]));
      check("R3", $sformatf("code %0d s-nearest", VEC[i][16:12]), int'(od[0]), int'(VEC[i][11:9]));
      check("R5", $sformatf("code %0d s-even", VEC[i][16:12]), int'(od[2]), int'(VEC[i][8:6]));
      check("R4", $sformatf("code %0d u-nearest", VEC[i][16:12]), int'(od[4]), int'(VEC[i][5:3]));
      check("R5", $sformatf("code %0d u-even", VEC[i][16:12]), int'(od[6]), int'(VEC[i][2:0]));
    end

    // full sweep of every code against the model
    for (int c = 0; c < 32; c++) begin
      apply(c);
      for (int g = 0; g < NCFG; g++)
        check(tag_of(g), $sformatf("cfg %0d code %0d", g, c), int'(od[g]),
              model(c, CS[g], CM[g], CSA[g]));
      check("R1", $sformatf("passthrough code %0d", c), int'(od_pass), c);
    end

    // overflow corners
    apply(15);
    check("R6", "s-nearest wrap at 15", int'(od[0]), 4);
    check("R7", "s-nearest clamp at 15", int'(od[1]), 3);
    check("R6", "s-even wrap at 15", int'(od[2]), 4);
    apply(31);
    check("R6", "u-nearest wrap at 31", int'(od[4]), 0);
    check("R7", "u-nearest clamp at 31", int'(od[5]), 7);
    check("R7", "u-even clamp at 31", int'(od[7]), 7);
    check("R2", "u-trunc at 31", int'(od[9]), 7);

    // R8 latency: one-cycle valid pulse carrying code 6
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    in_data  = 5'd6;
    in_valid = 1'b1;
    #1;
    check("R8", "lat0 valid at +0", int'(ov[2]), 1);
    check("R8", "lat1 valid at +0", int'(ov[1]), 0);
    check("R8", "lat2 valid at +0", int'(ov[0]), 0);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 5'd13;
    #1;
    check("R8", "lat0 valid at +1", int'(ov[2]), 0);
    check("R8", "lat1 valid at +1", int'(ov[1]), 1);
    check("R8", "lat1 data at +1", int'(od[1]), 2);
    check("R8", "lat2 valid at +1", int'(ov[0]), 0);
    @(negedge clk);
    check("R8", "lat1 valid at +2", int'(ov[1]), 0);
    check("R8", "lat2 valid at +2", int'(ov[0]), 1);
    check("R8", "lat2 data at +2", int'(od[0]), 2);

    // R9 hold while valid stays low and the data input changes
    repeat (3) @(negedge clk);
    check("R9", "lat2 holds", int'(od[0]), 2);
    check("R9", "lat1 holds", int'(od[1]), 2);
    check("R9", "lat2 valid low", int'(ov[0]), 0);

    // R10 asynchronous reset in mid-stream
    apply(10);
    #1;
    rst_n = 1'b0;
    #1;
    check("R10", "async clear valid", int'(ov[0]), 0);
    check("R10", "async clear data", int'(od[0]), 0);
    check("R10", "async clear lat1 valid", int'(ov[1]), 0);
    @(negedge clk);
    rst_n = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule